// File: doc/BRIEF.md
# Byte-to-Word Shared RAM Bridge

This block gives an 8-bit host bus access to a 128-entry, 32-bit working RAM. A 32-bit compute engine uses the same RAM, which is the main path for passing data between the two sides. The host works one byte at a time through holding registers:

- **Writes.** Bytes are gathered into a write holding register. The complete word goes into the RAM only when the top byte lane is written.
- **Reads.** Reading byte lane 0 fetches the whole word into a read holding register. The other lanes are then returned from that register.

Every host access is stretched by a number of wait states. A 2-bit ratio input, which describes how fast the host clock runs against the engine clock, selects that number. The engine has a request/grant port and always wins the RAM. A host access that needs the RAM simply waits for a cycle the engine leaves free.

The host port is a valid/ready handshake, and the host is the only source of back-pressure:
- The host raises `host_valid` with the access fields and holds all of them steady until it sees `host_ready`.
- The bridge raises `host_ready` for exactly one cycle, once the access is complete.
- Read data is presented on `host_rdata` in that same cycle.
- `host_valid` may be raised again in the cycle after the handshake.

Top module: `wordram_byte_bridge`

## Requirements
- R1: The RAM holds 128 words of 32 bits. Both sides can use it, and a word written by either side reads back identically from the other. The engine read data is presented combinationally in the cycle of its grant, and an engine write takes effect at the clock edge that ends the granted cycle.
- R2: A host byte address is split as follows. Bits [8:2] select the word and bits [1:0] select the byte lane. The layout is little-endian: lane 0 is word bits [7:0] and lane 3 is bits [31:24].
- R3: A host write to lanes 0, 1 or 2 only updates that byte of the write holding register and does not touch the RAM. A host write to lane 3 stores the word {lane 3 byte, held lanes 2..0} into the RAM. Held bytes stay in place after a commit, so a lane that was not rewritten reuses its earlier value.
- R4: A host read of lane 0 loads the full RAM word into the read holding register and returns bits [7:0]. A read of lanes 1 to 3 returns that lane from the read holding register without touching the RAM, so the returned byte may be stale until the next lane-0 read.
- R5: The wait count N depends on the ratio input: 0 gives 5, 1 gives 2, 2 gives 1, and the unused code 3 gives 5. Without engine contention, `host_ready` is low for exactly the first N cycles of `host_valid` and goes high in the cycle after them.
- R6: `eng_gnt` follows `eng_req` in every cycle. A host access that needs the RAM (a lane-3 write or a lane-0 read) and is due while `eng_req` is high completes in the first cycle with `eng_req` low. Host accesses that do not need the RAM are never delayed by the engine.
- R7: `host_ready` is never high in two consecutive cycles, and the access fields are taken when the access is accepted.
- R8: After reset `host_ready` is low and both holding registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ratio | input | 2 | Host-clock ratio code that selects the wait count |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = byte write, 0 = byte read |
| host_addr | input | 9 | Byte address: word in [8:2], lane in [1:0] |
| host_wdata | input | 8 | Write byte |
| host_ready | output | 1 | One-cycle completion of the host access |
| host_rdata | output | 8 | Read byte, valid while host_ready is high |
| eng_req | input | 1 | Engine RAM request |
| eng_we | input | 1 | Engine write enable |
| eng_addr | input | 7 | Engine word index |
| eng_wdata | input | 32 | Engine write word |
| eng_gnt | output | 1 | Engine grant |
| eng_rdata | output | 32 | Engine read word |

## Verification
The hardest situation to reach is a host access that has used up its wait states and then has to sit behind a held engine request. The access must not complete early, and it must not stall forever.

To get there, the stimulus holds `eng_req` high from before a lane-3 host write and releases it a known number of cycles later in a parallel thread. The expected completion cycle is then exact. Byte writes to lanes 0 to 2, which do not need the RAM, are issued under the same held request to show that they are not delayed.

Stale holding-register contents are reached on purpose. The bench reads upper lanes before any lane-0 read, and commits a word whose lane 2 was never rewritten.

// File: rtl/wrb_pkg.sv
package wrb_pkg;

  typedef enum logic [1:0] {
    RATIO_FULL    = 2'd0,
    RATIO_QUARTER = 2'd1,
    RATIO_EIGHTH  = 2'd2,
    RATIO_SPARE   = 2'd3
  } ratio_e;

  // Wait-state count for a ratio code; the spare code falls back to the slowest setting.
  function automatic int unsigned ws_for(input logic [1:0] code,
                                         input int unsigned w_full,
                                         input int unsigned w_quarter,
                                         input int unsigned w_eighth);
    case (ratio_e'(code))
      RATIO_QUARTER: return w_quarter;
      RATIO_EIGHTH:  return w_eighth;
      default:       return w_full;
    endcase
  endfunction

endpackage

// File: rtl/wrb_wait_timer.sv
module wrb_wait_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired,
  output logic [CNT_W-1:0] elapsed
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] elapsed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q  <= '0;
      elapsed_q <= '0;
    end else if (load) begin
      remain_q  <= load_val;
      elapsed_q <= '0;
    end else begin
      if (remain_q != '0)
        remain_q <= remain_q - CNT_W'(1);
      if (elapsed_q != CNT_MAX)
        elapsed_q <= elapsed_q + CNT_W'(1);
    end
  end

  assign expired = (remain_q == '0);
  assign elapsed = elapsed_q;

endmodule

// File: rtl/wrb_hold.sv
module wrb_hold #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [$clog2(LANES)-1:0]            wr_lane,
  input  logic [BYTE_W-1:0]                   wr_byte,
  input  logic                                cap_en,
  input  logic [LANES*BYTE_W-1:0]             cap_word,
  input  logic [$clog2(LANES)-1:0]            rd_lane,
  output logic [LANES*BYTE_W-1:0]             commit_word,
  output logic [BYTE_W-1:0]                   rd_byte
);

  localparam int LB = $clog2(LANES);
  localparam int WW = LANES * BYTE_W;

  logic [WW-1:0] wr_q;
  logic [WW-1:0] rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)
        wr_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_lane == LB'(g))
        wr_q[g*BYTE_W +: BYTE_W] <= wr_byte;
    end

    // The word being committed carries the incoming byte in its own lane.
    assign commit_word[g*BYTE_W +: BYTE_W] =
      (wr_lane == LB'(g)) ? wr_byte : wr_q[g*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_q <= '0;
    else if (cap_en)
      rd_q <= cap_word;
  end

  assign rd_byte = cap_en ? cap_word[rd_lane*BYTE_W +: BYTE_W]
                          : rd_q[rd_lane*BYTE_W +: BYTE_W];

  // R4: a capture loads the whole word; otherwise the read holding register is left alone.
  a_r4_capture_word: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> rd_q == $past(cap_word));
  a_r4_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> $stable(rd_q));

endmodule

// File: rtl/wrb_ram.sv
module wrb_ram #(
  parameter int WORDS  = 128,
  parameter int WORD_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      eng_en,
  input  logic                      eng_we,
  input  logic [$clog2(WORDS)-1:0]  eng_idx,
  input  logic [WORD_W-1:0]         eng_wdata,
  output logic [WORD_W-1:0]         eng_rdata,
  input  logic                      hst_en,
  input  logic                      hst_we,
  input  logic [$clog2(WORDS)-1:0]  hst_idx,
  input  logic [WORD_W-1:0]         hst_wdata,
  output logic [WORD_W-1:0]         hst_rdata
);

  logic [WORD_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (eng_en && eng_we)
      mem[eng_idx] <= eng_wdata;
    else if (hst_en && hst_we)
      mem[hst_idx] <= hst_wdata;
  end

  assign eng_rdata = mem[eng_idx];
  assign hst_rdata = mem[hst_idx];

  // R6: the two sides never use the array in the same cycle.
  a_r6_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(eng_en && hst_en));
  // R3: a host commit lands in the addressed word.
  a_r3_commit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_en && hst_we) |=> mem[$past(hst_idx)] == $past(hst_wdata));

endmodule

// File: rtl/wordram_byte_bridge.sv
module wordram_byte_bridge #(
  parameter int WORDS      = 128,
  parameter int WORD_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int WS_FULL    = 5,
  parameter int WS_QUARTER = 2,
  parameter int WS_EIGHTH  = 1
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic [1:0]                                   cfg_ratio,
  input  logic                                         host_valid,
  input  logic                                         host_write,
  input  logic [$clog2(WORDS)+$clog2(WORD_W/BYTE_W)-1:0] host_addr,
  input  logic [BYTE_W-1:0]                            host_wdata,
  output logic                                         host_ready,
  output logic [BYTE_W-1:0]                            host_rdata,
  input  logic                                         eng_req,
  input  logic                                         eng_we,
  input  logic [$clog2(WORDS)-1:0]                     eng_addr,
  input  logic [WORD_W-1:0]                            eng_wdata,
  output logic                                         eng_gnt,
  output logic [WORD_W-1:0]                            eng_rdata
);

  localparam int LANES     = WORD_W / BYTE_W;
  localparam int LANE_BITS = $clog2(LANES);
  localparam int IDX_W     = $clog2(WORDS);
  localparam int ADDR_W    = IDX_W + LANE_BITS;
  localparam int CNT_W     = $clog2(WS_FULL + 1);
  localparam logic [LANE_BITS-1:0] TOP_LANE = LANE_BITS'(LANES - 1);

  // Access latched at acceptance
  logic              busy_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] wdata_q;
  logic [CNT_W-1:0]  ws_q;

  logic [CNT_W-1:0]     ws_now;
  logic                 accept;
  logic                 expired;
  logic [CNT_W-1:0]     elapsed;
  logic [LANE_BITS-1:0] lane;
  logic [IDX_W-1:0]     idx;
  logic                 need_ram;
  logic                 host_go;
  logic [WORD_W-1:0]    commit_word;
  logic [WORD_W-1:0]    ram_hst_rdata;

  assign ws_now = CNT_W'(wrb_pkg::ws_for(cfg_ratio, WS_FULL, WS_QUARTER, WS_EIGHTH));
  assign accept = !busy_q && host_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      ws_q    <= '0;
    end else if (accept) begin
      busy_q  <= 1'b1;
      wr_q    <= host_write;
      addr_q  <= host_addr;
      wdata_q <= host_wdata;
      ws_q    <= ws_now;
    end else if (host_go) begin
      busy_q  <= 1'b0;
    end
  end

  // The first request cycle counts as one wait state, so the timer starts at N-1.
  wrb_wait_timer #(.CNT_W(CNT_W)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (ws_now - CNT_W'(1)),
    .expired  (expired),
    .elapsed  (elapsed)
  );

  assign lane     = addr_q[LANE_BITS-1:0];
  assign idx      = addr_q[ADDR_W-1:LANE_BITS];
  assign need_ram = wr_q ? (lane == TOP_LANE) : (lane == '0);
  // The engine always wins; only a RAM-bound host access yields.
  assign host_go  = busy_q && expired && (!need_ram || !eng_req);

  assign host_ready = host_go;
  assign eng_gnt    = eng_req;

  wrb_hold #(.LANES(LANES), .BYTE_W(BYTE_W)) i_hold (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (host_go && wr_q),
    .wr_lane     (lane),
    .wr_byte     (wdata_q),
    .cap_en      (host_go && !wr_q && need_ram),
    .cap_word    (ram_hst_rdata),
    .rd_lane     (lane),
    .commit_word (commit_word),
    .rd_byte     (host_rdata)
  );

  wrb_ram #(.WORDS(WORDS), .WORD_W(WORD_W)) i_ram (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_en    (eng_req),
    .eng_we    (eng_we),
    .eng_idx   (eng_addr),
    .eng_wdata (eng_wdata),
    .eng_rdata (eng_rdata),
    .hst_en    (host_go && need_ram),
    .hst_we    (wr_q),
    .hst_idx   (idx),
    .hst_wdata (commit_word),
    .hst_rdata (ram_hst_rdata)
  );

  logic [CNT_W:0] elapsed_p1;
  assign elapsed_p1 = {1'b0, elapsed} + (CNT_W+1)'(1);

  // R7: a completion pulse lasts one cycle.
  a_r7_single_ready: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |=> !host_ready);
  // R5: completion never comes before the selected wait count has run.
  a_r5_min_wait: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> elapsed_p1 >= {1'b0, ws_q});

endmodule

// File: tb/test_wordram_byte_bridge.sv
`timescale 1ns/100ps
module test_wordram_byte_bridge;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_ratio = 2'd0;
  logic        host_valid = 1'b0;
  logic        host_write = 1'b0;
  logic [8:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_ready;
  logic [7:0]  host_rdata;
  logic        eng_req = 1'b0;
  logic        eng_we = 1'b0;
  logic [6:0]  eng_addr = '0;
  logic [31:0] eng_wdata = '0;
  logic        eng_gnt;
  logic [31:0] eng_rdata;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  wordram_byte_bridge i_wordram_byte_bridge (
    .clk(clk), .rst_n(rst_n), .cfg_ratio(cfg_ratio),
    .host_valid(host_valid), .host_write(host_write), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_ready(host_ready), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
    .eng_wdata(eng_wdata), .eng_gnt(eng_gnt), .eng_rdata(eng_rdata)
  );

  typedef struct packed {
    logic [1:0] cfg;
    logic       wr;
    logic [8:0] addr;
    logic [7:0] data;   // write byte, or expected read byte
    logic [2:0] waits;
  } vec_t;

  localparam int NVEC = 20;
  localparam vec_t VEC [NVEC] = '{
    '{2'd0, 1'b1, 9'd20,  8'h11, 3'd5},
    '{2'd0, 1'b1, 9'd21,  8'h22, 3'd5},
    '{2'd0, 1'b1, 9'd22,  8'h33, 3'd5},
    '{2'd0, 1'b1, 9'd23,  8'h44, 3'd5},
    '{2'd0, 1'b0, 9'd20,  8'h11, 3'd5},
    '{2'd0, 1'b0, 9'd23,  8'h44, 3'd5},
    '{2'd0, 1'b0, 9'd21,  8'h22, 3'd5},
    '{2'd1, 1'b1, 9'd508, 8'hAA, 3'd2},
    '{2'd1, 1'b1, 9'd509, 8'hBB, 3'd2},
    '{2'd1, 1'b1, 9'd510, 8'hCC, 3'd2},
    '{2'd1, 1'b1, 9'd511, 8'hDD, 3'd2},
    '{2'd1, 1'b0, 9'd510, 8'h33, 3'd2},   // stale: still word 5
    '{2'd1, 1'b0, 9'd508, 8'hAA, 3'd2},
    '{2'd1, 1'b0, 9'd511, 8'hDD, 3'd2},
    '{2'd2, 1'b1, 9'd8,   8'h01, 3'd1},
    '{2'd2, 1'b1, 9'd9,   8'h02, 3'd1},
    '{2'd2, 1'b1, 9'd11,  8'h04, 3'd1},   // lane 2 reuses CC
    '{2'd2, 1'b0, 9'd8,   8'h01, 3'd1},
    '{2'd2, 1'b0, 9'd10,  8'hCC, 3'd1},
    '{2'd3, 1'b0, 9'd9,   8'h02, 3'd5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Starts at a negedge; returns at a negedge with the request dropped.
  task automatic host_op(input logic wr, input logic [8:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output int waits);
    host_valid = 1'b1; host_write = wr; host_addr = a; host_wdata = d;
    waits = 0;
    #1;
    while (!host_ready) begin
      waits++;
      @(negedge clk); #1;
    end
    rd = host_rdata;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic eng_write(input logic [6:0] a, input logic [31:0] d);
    eng_req = 1'b1; eng_we = 1'b1; eng_addr = a; eng_wdata = d;
    @(negedge clk);
    eng_req = 1'b0; eng_we = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    int w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R8 ready low after reset", 32'(host_ready), 32'd0);
    chk("R6 no grant without request", 32'(eng_gnt), 32'd0);
    @(negedge clk);

    // R8 / R4: lane 1 read straight after reset returns the cleared holding register
    cfg_ratio = 2'd2;
    host_op(1'b0, 9'd1, 8'h00, rd, w);
    chk("R8 read hold cleared", 32'(rd), 32'h0);
    chk("R5 ratio 2 waits", 32'(w), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      cfg_ratio = VEC[i].cfg;
      host_op(VEC[i].wr, VEC[i].addr, VEC[i].data, rd, w);
      chk("R5 wait count", 32'(w), 32'(VEC[i].waits));
      if (!VEC[i].wr)
        chk("R2 R3 R4 read byte", 32'(rd), 32'(VEC[i].data));
    end

    // R1: engine sees host-committed words
    eng_req = 1'b1; eng_we = 1'b0; eng_addr = 7'd5;
    #1;
    chk("R6 grant follows request", 32'(eng_gnt), 32'd1);
    chk("R1 engine reads word 5", eng_rdata, 32'h44332211);
    eng_addr = 7'd2; #1;
    chk("R3 engine reads word 2", eng_rdata, 32'h04CC0201);
    eng_addr = 7'd127; #1;
    chk("R2 engine reads word 127", eng_rdata, 32'hDDCCBBAA);
    @(negedge clk);
    eng_req = 1'b0;

    // R1: host sees an engine write, little-endian lanes
    eng_write(7'd9, 32'hDEADBEEF);
    cfg_ratio = 2'd2;
    host_op(1'b0, 9'd36, 8'h00, rd, w);
    chk("R1 host lane0 of engine word", 32'(rd), 32'hEF);
    host_op(1'b0, 9'd39, 8'h00, rd, w);
    chk("R2 host lane3 of engine word", 32'(rd), 32'hDE);

    // R6: byte writes under a held engine request are not delayed
    eng_req = 1'b1; eng_we = 1'b0; eng_addr = 7'd2;
    host_op(1'b1, 9'd24, 8'h61, rd, w);
    chk("R6 lane0 write not delayed", 32'(w), 32'd1);
    host_op(1'b1, 9'd25, 8'h62, rd, w);
    host_op(1'b1, 9'd26, 8'h63, rd, w);
    chk("R6 lane2 write not delayed", 32'(w), 32'd1);

    // R6: commit waits until the engine releases
    fork
      host_op(1'b1, 9'd27, 8'h64, rd, w);
      begin
        repeat (3) @(negedge clk);
        #1;
        chk("R6 host held while engine busy", 32'(host_ready), 32'd0);
        @(negedge clk);
        eng_req = 1'b0;
      end
    join
    chk("R6 commit extended", 32'(w), 32'd4);
    eng_req = 1'b1; eng_addr = 7'd6; #1;
    chk("R3 committed word 6", eng_rdata, 32'h64636261);
    @(negedge clk);
    eng_req = 1'b0;

    // R7: fields latched at acceptance; changing them mid-access has no effect
    cfg_ratio = 2'd0;
    host_valid = 1'b1; host_write = 1'b0; host_addr = 9'd24; host_wdata = 8'h00;
    @(negedge clk);
    host_addr = 9'd36;
    cfg_ratio = 2'd2;
    w = 1;
    #1;
    while (!host_ready) begin w++; @(negedge clk); #1; end
    chk("R7 latched address", 32'(host_rdata), 32'h61);
    chk("R7 latched ratio", 32'(w), 32'd5);
    @(negedge clk);
    #1;
    chk("R7 ready single cycle", 32'(host_ready), 32'd0);
    host_valid = 1'b0;
    @(negedge clk);

    finish_run();
  end

endmodule